// File: doc/BRIEF.md
# Word-Mark Clearing Sequencer

This block runs one instruction of a character-oriented machine: it removes the word-mark flag from one or two storage characters and leaves their data bits alone. A start pulse comes in with the decoded instruction length and the A and B operand addresses. The block then runs a single-port character memory through read and write cycles. For each operand it reads the character, writes it back with the flag bit forced low, and decrements the operand's address register.

The instruction length selects the form. Length 7 loads both addresses and clears A and then B. Length 4 loads only A and clears only that operand. Length 1 is the chained form: it keeps the address registers left by the previous instruction and runs as the two-operand form. Before any storage cycle the block checks the length, then the A address, then the B address. A failed check ends the instruction with an error status. The current storage-cycle type is shown on an output so the access order can be observed.

Top module: `wm_clear_seq`

## Requirements
- R1: A length other than 1, 4 or 7 ends the instruction with `ill_len_o`. There is no memory request, the address registers keep their values, and `done_o` appears two clocks after the start edge.
- R2: An address of 0 or of at least `DEPTH` is invalid. Checks run in this order: length, then A, then B. An invalid A or B gives `proc_err_o`, with `cycle_o` equal to 1 (A) or 2 (B) during done. No memory request is made, and the registers hold the values loaded at start.
- R3: For a legal two-operand instruction, four storage cycles run back to back from the second clock after start: read A, write A, read B, write B. Each write goes to the address just read. `cycle_o` reads 1 during A cycles and 2 during B cycles, and `done_o` follows in the next clock (six clocks after start).
- R4: Each written character equals the character read one clock earlier with bit 7 (the word mark) cleared. Bits 6..0 are unchanged.
- R5: After a two-operand instruction, the A register holds A−1 and the B register holds B−1.
- R6: For length 4, only the A location is read and written. Both address registers end at A−1, and `done_o` comes four clocks after start. The B address input is ignored.
- R7: For length 1, the address inputs are ignored and the registers left by the previous instruction are used.
- R8: `done_o` is a one-clock pulse. Exactly one of `ok_o`, `ill_len_o`, `proc_err_o` is high with it, and all three are low otherwise.
- R9: After reset the block is idle. There is no request and no done, and both address registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse, taken when idle |
| len_i | input | 3 | Decoded instruction length |
| a_addr_i | input | AW | A operand address |
| b_addr_i | input | AW | B operand address |
| mem_req_o | output | 1 | Storage cycle request |
| mem_we_o | output | 1 | Storage cycle is a write |
| mem_addr_o | output | AW | Storage address |
| mem_wdata_o | output | DW | Write data |
| mem_rdata_i | input | DW | Read data, one clock after a read request |
| a_addr_o | output | AW | A address register |
| b_addr_o | output | AW | B address register |
| cycle_o | output | 2 | Cycle type: 0 I, 1 A, 2 B |
| busy_o | output | 1 | Instruction in progress |
| done_o | output | 1 | Completion pulse |
| ok_o | output | 1 | Completed without error |
| ill_len_o | output | 1 | Illegal length |
| proc_err_o | output | 1 | Invalid address |

## Verification
The length check and the address checks are evaluated in the same clock. The bench starts instructions that carry both an illegal length and a zero A address, and it requires the length error to win with no storage cycle. In the length-4 write clock, the A decrement and the copy of that decremented value into B also fall together. The bench judges this from both registers after done, and from a following chained instruction that must reuse those values.

// File: rtl/wmc_pkg.sv
package wmc_pkg;
  typedef enum logic [1:0] {CYC_I = 2'd0, CYC_A = 2'd1, CYC_B = 2'd2} cyc_e;

  typedef enum logic [2:0] {
    S_IDLE, S_CHK, S_RD_A, S_WR_A, S_RD_B, S_WR_B, S_DONE
  } st_e;

  localparam int unsigned LEN_CHAIN = 1;
  localparam int unsigned LEN_ONE   = 4;
  localparam int unsigned LEN_TWO   = 7;
endpackage

// File: rtl/wmc_len_dec.sv
module wmc_len_dec import wmc_pkg::*; #(
  parameter int unsigned LW = 3
) (
  input  logic [LW-1:0] len_i,
  output logic          legal_o,
  output logic          two_op_o,
  output logic          chained_o
);
  always_comb begin
    chained_o = (len_i == LW'(LEN_CHAIN));
    two_op_o  = chained_o || (len_i == LW'(LEN_TWO));
    legal_o   = two_op_o || (len_i == LW'(LEN_ONE));
  end
endmodule

// File: rtl/wmc_addr_chk.sv
module wmc_addr_chk #(
  parameter int unsigned AW    = 14,
  parameter int unsigned DEPTH = 16000
) (
  input  logic [AW-1:0] addr_i,
  output logic          bad_o
);
  localparam logic [AW:0] LIMIT = (AW+1)'(DEPTH);

  // location zero may not have its mark cleared
  always_comb bad_o = (addr_i == '0) || ({1'b0, addr_i} >= LIMIT);
endmodule

// File: rtl/wmc_addr_regs.sv
module wmc_addr_regs #(
  parameter int unsigned AW    = 14,
  parameter int unsigned DEPTH = 16000
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_i,
  input  logic          ld_one_i,
  input  logic [AW-1:0] a_in_i,
  input  logic [AW-1:0] b_in_i,
  input  logic          dec_a_i,
  input  logic          dec_b_i,
  input  logic          b_from_a_i,
  output logic [AW-1:0] a_q_o,
  output logic [AW-1:0] b_q_o
);
  localparam logic [AW-1:0] TOP = AW'(DEPTH - 1);

  logic [AW-1:0] a_dec, b_dec;

  always_comb begin
    a_dec = (a_q_o == '0) ? TOP : a_q_o - AW'(1);
    b_dec = (b_q_o == '0) ? TOP : b_q_o - AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q_o <= '0;
      b_q_o <= '0;
    end else if (ld_i) begin
      a_q_o <= a_in_i;
      b_q_o <= ld_one_i ? a_in_i : b_in_i;
    end else begin
      if (dec_a_i) a_q_o <= a_dec;
      if (b_from_a_i)   b_q_o <= a_dec;
      else if (dec_b_i) b_q_o <= b_dec;
    end
  end
endmodule

// File: rtl/wmc_ctrl.sv
module wmc_ctrl import wmc_pkg::*; (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic       legal_i,
  input  logic       two_op_i,
  input  logic       chained_i,
  input  logic       a_bad_i,
  input  logic       b_bad_i,
  output logic       ld_o,
  output logic       ld_one_o,
  output logic       dec_a_o,
  output logic       dec_b_o,
  output logic       b_from_a_o,
  output logic       mem_req_o,
  output logic       mem_we_o,
  output logic       sel_b_o,
  output logic [1:0] cycle_o,
  output logic       busy_o,
  output logic       done_o,
  output logic       ok_o,
  output logic       ill_o,
  output logic       perr_o
);
  st_e  state_q, state_d;
  logic legal_q, two_q;
  logic ok_q, ill_q, perr_q;
  cyc_e err_cyc_q;

  always_comb begin
    state_d    = state_q;
    ld_o       = 1'b0;
    ld_one_o   = 1'b0;
    dec_a_o    = 1'b0;
    dec_b_o    = 1'b0;
    b_from_a_o = 1'b0;
    mem_req_o  = 1'b0;
    mem_we_o   = 1'b0;
    sel_b_o    = 1'b0;
    cycle_o    = CYC_I;
    done_o     = 1'b0;
    unique case (state_q)
      S_IDLE: if (start_i) begin
        state_d  = S_CHK;
        ld_o     = legal_i && !chained_i;
        ld_one_o = !two_op_i;
      end
      S_CHK: state_d = (!legal_q || a_bad_i || b_bad_i) ? S_DONE : S_RD_A;
      S_RD_A: begin
        mem_req_o = 1'b1;
        cycle_o   = CYC_A;
        state_d   = S_WR_A;
      end
      S_WR_A: begin
        mem_req_o  = 1'b1;
        mem_we_o   = 1'b1;
        cycle_o    = CYC_A;
        dec_a_o    = 1'b1;
        b_from_a_o = !two_q;
        state_d    = two_q ? S_RD_B : S_DONE;
      end
      S_RD_B: begin
        mem_req_o = 1'b1;
        sel_b_o   = 1'b1;
        cycle_o   = CYC_B;
        state_d   = S_WR_B;
      end
      S_WR_B: begin
        mem_req_o = 1'b1;
        mem_we_o  = 1'b1;
        sel_b_o   = 1'b1;
        cycle_o   = CYC_B;
        dec_b_o   = 1'b1;
        state_d   = S_DONE;
      end
      S_DONE: begin
        done_o  = 1'b1;
        cycle_o = err_cyc_q;
        state_d = S_IDLE;
      end
      default: state_d = S_DONE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      legal_q   <= 1'b0;
      two_q     <= 1'b0;
      ok_q      <= 1'b0;
      ill_q     <= 1'b0;
      perr_q    <= 1'b0;
      err_cyc_q <= CYC_I;
    end else begin
      state_q <= state_d;
      case (state_q)
        S_IDLE: if (start_i) begin
          legal_q   <= legal_i;
          two_q     <= two_op_i;
          ok_q      <= 1'b0;
          ill_q     <= 1'b0;
          perr_q    <= 1'b0;
          err_cyc_q <= CYC_I;
        end
        S_CHK: begin
          if (!legal_q) ill_q <= 1'b1;
          else if (a_bad_i) begin
            perr_q    <= 1'b1;
            err_cyc_q <= CYC_A;
          end else if (b_bad_i) begin
            perr_q    <= 1'b1;
            err_cyc_q <= CYC_B;
          end
        end
        S_WR_A: if (!two_q) ok_q <= 1'b1;
        S_WR_B: ok_q <= 1'b1;
        S_RD_A, S_RD_B, S_DONE: ;
        default: begin
          ok_q   <= 1'b0;
          ill_q  <= 1'b0;
          perr_q <= 1'b1;
        end
      endcase
    end
  end

  always_comb begin
    busy_o = (state_q != S_IDLE);
    ok_o   = done_o && ok_q;
    ill_o  = done_o && ill_q;
    perr_o = done_o && perr_q;
  end
endmodule

// File: rtl/wm_clear_seq.sv
module wm_clear_seq import wmc_pkg::*; #(
  parameter int unsigned AW     = 14,
  parameter int unsigned DEPTH  = 16000,
  parameter int unsigned DW     = 8,
  parameter int unsigned WM_BIT = 7
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [2:0]    len_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [AW-1:0] b_addr_i,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [AW-1:0] a_addr_o,
  output logic [AW-1:0] b_addr_o,
  output logic [1:0]    cycle_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          ok_o,
  output logic          ill_len_o,
  output logic          proc_err_o
);
  localparam logic [DW-1:0] WM_MASK = DW'(1) << WM_BIT;

  logic legal, two_op, chained;
  logic ld, ld_one, dec_a, dec_b, b_from_a, sel_b;
  logic [1:0][AW-1:0] chk_addr;
  logic [1:0]         chk_bad;

  wmc_len_dec #(.LW(3)) u_len (
    .len_i(len_i), .legal_o(legal), .two_op_o(two_op), .chained_o(chained)
  );

  wmc_addr_regs #(.AW(AW), .DEPTH(DEPTH)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .ld_i(ld), .ld_one_i(ld_one),
    .a_in_i(a_addr_i), .b_in_i(b_addr_i), .dec_a_i(dec_a), .dec_b_i(dec_b),
    .b_from_a_i(b_from_a), .a_q_o(a_addr_o), .b_q_o(b_addr_o)
  );

  assign chk_addr[0] = a_addr_o;
  assign chk_addr[1] = b_addr_o;

  for (genvar g = 0; g < 2; g++) begin : g_chk
    wmc_addr_chk #(.AW(AW), .DEPTH(DEPTH)) u_addr_chk (
      .addr_i(chk_addr[g]), .bad_o(chk_bad[g])
    );
  end

  wmc_ctrl u_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .legal_i(legal), .two_op_i(two_op), .chained_i(chained),
    .a_bad_i(chk_bad[0]), .b_bad_i(chk_bad[1]),
    .ld_o(ld), .ld_one_o(ld_one), .dec_a_o(dec_a), .dec_b_o(dec_b),
    .b_from_a_o(b_from_a), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .sel_b_o(sel_b), .cycle_o(cycle_o), .busy_o(busy_o), .done_o(done_o),
    .ok_o(ok_o), .ill_o(ill_len_o), .perr_o(proc_err_o)
  );

  assign mem_addr_o  = sel_b ? b_addr_o : a_addr_o;
  assign mem_wdata_o = mem_rdata_i & ~WM_MASK;
endmodule

// File: rtl/wm_clear_seq_chk.sv
module wm_clear_seq_chk #(
  parameter int unsigned AW     = 14,
  parameter int unsigned DW     = 8,
  parameter int unsigned WM_BIT = 7
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [2:0]    len_i,
  input logic          mem_req_o,
  input logic          mem_we_o,
  input logic [AW-1:0] mem_addr_o,
  input logic [DW-1:0] mem_wdata_o,
  input logic [AW-1:0] a_addr_o,
  input logic [1:0]    cycle_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          ok_o,
  input logic          ill_len_o,
  input logic          proc_err_o
);
  AST_WR_CLEARS_MARK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> !mem_wdata_o[WM_BIT]); // R4
  AST_WR_AFTER_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && mem_we_o |-> $past(mem_req_o && !mem_we_o) && mem_addr_o == $past(mem_addr_o)); // R3
  AST_ACCESS_TYPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> cycle_o != 2'd0); // R3
  AST_NO_ZERO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o != '0); // R2
  AST_ILL_NO_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && ill_len_o |-> $past(!mem_req_o)); // R1
  AST_ONE_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> $countones({ok_o, ill_len_o, proc_err_o}) == 1); // R8
  AST_STATUS_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> !(ok_o || ill_len_o || proc_err_o)); // R8
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R8
  AST_CHAIN_KEEPS_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_o && len_i == 3'd1 |=> $stable(a_addr_o)); // R7
endmodule

bind wm_clear_seq wm_clear_seq_chk #(.AW(AW), .DW(DW), .WM_BIT(WM_BIT)) u_sva (
  .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .len_i(len_i),
  .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
  .mem_wdata_o(mem_wdata_o), .a_addr_o(a_addr_o), .cycle_o(cycle_o),
  .busy_o(busy_o), .done_o(done_o), .ok_o(ok_o), .ill_len_o(ill_len_o),
  .proc_err_o(proc_err_o)
);

// File: tb/wm_clear_seq_bench.sv
module wm_clear_seq_bench;
  localparam int AW = 14;
  localparam int DEPTH = 1024;
  localparam int DW = 8;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
    logic [1:0]    cyc;
  } acc_t;

  typedef struct packed {
    logic          ok;
    logic          ill;
    logic          perr;
    logic [1:0]    cyc;
    logic [AW-1:0] a;
    logic [AW-1:0] b;
  } res_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0;
  logic [2:0] len = '0;
  logic [AW-1:0] a_in = '0, b_in = '0;
  logic mem_req, mem_we, busy, done, ok, ill, perr;
  logic [AW-1:0] mem_addr, a_out, b_out;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic [1:0] cyc;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] sh  [DEPTH];
  acc_t acc_q[$];
  res_t res_q[$];
  int checks = 0, fails = 0;
  logic [AW-1:0] ea = '0, eb = '0;

  always #10 clk = ~clk;

  wm_clear_seq #(.AW(AW), .DEPTH(DEPTH), .DW(DW), .WM_BIT(7)) u_wm_clear_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .len_i(len),
    .a_addr_i(a_in), .b_addr_i(b_in), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .a_addr_o(a_out), .b_addr_o(b_out), .cycle_o(cyc), .busy_o(busy),
    .done_o(done), .ok_o(ok), .ill_len_o(ill), .proc_err_o(perr)
  );

  always_ff @(posedge clk) begin
    if (mem_req && mem_we) mem[mem_addr] <= mem_wdata;
    if (mem_req && !mem_we) mem_rdata <= mem[mem_addr];
  end

  task automatic chk(input bit cond, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pop expected items as the design produces them
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_req) begin
        if (acc_q.size() == 0) chk(1'b0, "R1/R2 unexpected access", {mem_we, mem_addr}, 0);
        else begin
          acc_t e;
          e = acc_q.pop_front();
          chk(mem_we == e.we && mem_addr == e.addr && cyc == e.cyc, "R3 access",
              {mem_we, cyc, mem_addr}, {e.we, e.cyc, e.addr});
          if (e.we) chk(mem_wdata == e.data, "R4 wdata", mem_wdata, e.data);
        end
      end
      if (done) begin
        if (res_q.size() == 0) chk(1'b0, "R8 unexpected done", 1, 0);
        else begin
          res_t r;
          r = res_q.pop_front();
          chk({ok, ill, perr, cyc} == {r.ok, r.ill, r.perr, r.cyc}, "R1/R2/R8 status",
              {ok, ill, perr, cyc}, {r.ok, r.ill, r.perr, r.cyc});
          chk(a_out == r.a && b_out == r.b, "R5/R6 regs", {a_out, b_out}, {r.a, r.b});
        end
      end
    end
  end

  function automatic bit bad(input logic [AW-1:0] x);
    return (x == '0) || (int'(x) >= DEPTH);
  endfunction

  function automatic logic [AW-1:0] dec(input logic [AW-1:0] x);
    return (x == '0) ? AW'(DEPTH - 1) : x - AW'(1);
  endfunction

  task automatic run_op(input logic [2:0] l, input logic [AW-1:0] a, input logic [AW-1:0] b, input string req);
    res_t r;
    int k_exp, k;
    r = '0;
    if (!(l == 3'd1 || l == 3'd4 || l == 3'd7)) begin
      r.ill = 1'b1; k_exp = 2;
    end else begin
      if (l != 3'd1) begin ea = a; eb = (l == 3'd4) ? a : b; end
      if (bad(ea)) begin r.perr = 1'b1; r.cyc = 2'd1; k_exp = 2; end
      else if (bad(eb)) begin r.perr = 1'b1; r.cyc = 2'd2; k_exp = 2; end
      else begin
        acc_q.push_back('{1'b0, ea, '0, 2'd1});
        sh[ea] = sh[ea] & 8'h7f;
        acc_q.push_back('{1'b1, ea, sh[ea], 2'd1});
        ea = dec(ea);
        if (l == 3'd4) begin eb = ea; k_exp = 4; end
        else begin
          acc_q.push_back('{1'b0, eb, '0, 2'd2});
          sh[eb] = sh[eb] & 8'h7f;
          acc_q.push_back('{1'b1, eb, sh[eb], 2'd2});
          eb = dec(eb);
          k_exp = 6;
        end
        r.ok = 1'b1;
      end
    end
    r.a = ea; r.b = eb;
    res_q.push_back(r);
    @(negedge clk);
    start = 1'b1; len = l; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0; a_in = 14'h3ff5; b_in = 14'h3ffa;
    k = 1;
    while (!done && k < 20) begin @(negedge clk); k++; end
    chk(k == k_exp, {req, " done latency"}, k, k_exp);
    @(negedge clk);
    chk(!done && !busy, "R8 done pulse", {done, busy}, 0);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finish");
    finish_run();
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(i * 73 + 5);
      sh[i]  = DW'(i * 73 + 5);
    end
    repeat (3) @(negedge clk);
    chk(!mem_req && !done && !busy && a_out == 0 && b_out == 0, "R9 reset",
        {mem_req, done, busy, a_out, b_out}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    run_op(3'd7, 14'd100, 14'd200, "R3 R5 two-op");
    run_op(3'd1, 14'd0, 14'd0, "R7 chained");
    run_op(3'd4, 14'd300, 14'd500, "R6 one-op");
    run_op(3'd1, 14'd7, 14'd9, "R7 chained after one-op");
    for (int l = 0; l < 8; l++)
      if (!(l == 1 || l == 4 || l == 7)) run_op(3'(l), 14'd20, 14'd30, "R1 illegal");
    run_op(3'd2, 14'd0, 14'd0, "R1 R2 length first");
    run_op(3'd7, 14'd0, 14'd50, "R2 A zero");
    run_op(3'd7, 14'd10, 14'd0, "R2 B zero");
    run_op(3'd7, 14'd2000, 14'd0, "R2 A high");
    run_op(3'd7, 14'd5, 14'd1500, "R2 B high");
    run_op(3'd4, 14'd0, 14'd9, "R2 R6 one-op zero");
    run_op(3'd7, 14'd40, 14'd40, "R4 same location");
    run_op(3'd7, 14'd1, 14'd1023, "R5 low and top");
    run_op(3'd1, 14'd0, 14'd0, "R2 R7 chained onto zero");
    run_op(3'd7, 14'd17, 14'd18, "R4 already clear");
    repeat (3) @(negedge clk);
    chk(acc_q.size() == 0 && res_q.size() == 0, "R3 all items seen",
        {acc_q.size(), res_q.size()}, 0);
    begin
      int bad_n;
      bad_n = 0;
      for (int i = 0; i < DEPTH; i++) if (mem[i] !== sh[i]) bad_n++;
      chk(bad_n == 0, "R4 memory image", bad_n, 0);
    end
    finish_run();
  end
endmodule